// File: doc/BRIEF.md
# Serial Converter Control-Word Interface

This block is the digital serial front end of a data converter. A host lowers chip select and clocks in a 16-bit control word, most significant bit first. During the same frame the block clocks out the 16-bit result of the previous conversion. When chip select rises, the top bit of the received word decides what happens. If it is set, the lower fifteen bits become the new configuration and a conversion is requested. If it is clear, the word acts as a no-operation: the configuration stays as it is and the conversion sequencer returns to idle. Because of this, devices connected in a daisy chain can be reconfigured one at a time.

The configuration is decoded into the following controls: analog power-down, oscillator power-down, offset-null, gain-calibrate, channel select, clock-divider select and conversion-time select. A small sequencer drives an active-low busy line. A conversion-done strobe carries a result word into the I/O register and releases busy. If a conversion is requested while the oscillator is off, or while it is being turned off, busy sticks low. Only a no-operation word clears that state. The serial clock, chip select and serial data are synchronized into the system clock before any of them is used.

Top module: `sadc_ctrl_if`

## Requirements
- R1: After reset the configuration is all zero, busy_n_o is 1, osc_en_o is 1 and sdo_oe_o is 0. The first frame after reset shifts out sixteen zero bits.
- R2: Serial data is sampled on rising serial-clock edges, most significant bit first. A 16-clock frame whose bit 15 is 1 loads bits 14..0 into the configuration when chip select rises.
- R3: A 16-clock frame whose bit 15 is 0 leaves the configuration unchanged, starts no conversion and returns busy_n_o to 1, even while a conversion is running.
- R4: The I/O register is shifted out on sdo_o, most significant bit first. The first bit appears after chip select falls, and each later bit appears after a falling serial-clock edge. sdo_oe_o is 1 only while chip select is low.
- R5: The configuration fields are decoded as follows: bit 0 to apd_o, bit 1 to oscillator power-down (osc_en_o is its inverse), bit 2 to null_o, bit 3 to gcal_o, bit 4 to chan_o (1 selects channel 2), bits 8..7 to div_sel_o and bits 12..9 to time_sel_o.
- R6: A commit while the oscillator is both running and staying on gives exactly one conv_start_o pulse and drives busy_n_o to 0.
- R7: A done_i strobe while a conversion runs and no frame is open loads result_i into the I/O register and sets busy_n_o to 1. A done_i strobe during a frame, or while no conversion is running, has no effect.
- R8: A committed word with bit 1 set drives osc_en_o to 0 after chip select rises. A later committed word with bit 1 clear drives it back to 1.
- R9: A commit made while the old or the new configuration has bit 1 set gives no conv_start_o pulse and holds busy_n_o at 0. done_i does not release this state; only a no-operation word does.
- R10: A frame with other than 16 serial clocks changes neither the configuration, the sequencer nor the I/O register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles low |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (tri-state control) |
| done_i | input | 1 | Conversion-done strobe |
| result_i | input | 16 | Result word carried by done_i |
| busy_n_o | output | 1 | Low while a conversion is pending or stalled |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| osc_en_o | output | 1 | Oscillator enable |
| apd_o | output | 1 | Analog power-down |
| null_o | output | 1 | Offset-null mode |
| gcal_o | output | 1 | Gain-calibration mode |
| chan_o | output | 1 | Channel select, 1 = channel 2 |
| div_sel_o | output | 2 | Clock-divider select |
| time_sel_o | output | 4 | Conversion-time select |

## Verification
The bench sends committing words with different field patterns and checks each decoded output. This separates a wrong field position from a wrong commit decision. No-operation words sent while idle, during a conversion and during a stall show whether the flag only resets the sequencer or also touches the configuration. Frames of 15 and 17 clocks, and done strobes sent during a frame or while idle, must leave every output and the next read-back word unchanged. The oscillator power-down sequence (power down, re-enable while stalled, dummy word, normal conversion) separates a stall that depends on the old configuration from one that depends on the new one.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int WORD_W = 16;
  localparam int CFG_W  = WORD_W - 1;
  localparam int FLAG_BIT = WORD_W - 1;

  localparam int F_APD  = 0;
  localparam int F_OPD  = 1;
  localparam int F_NULL = 2;
  localparam int F_GCAL = 3;
  localparam int F_CHAN = 4;
  localparam int F_DIV_LO = 7;
  localparam int F_DIV_W  = 2;
  localparam int F_TIME_LO = 9;
  localparam int F_TIME_W  = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_STALL} seq_st_t;

  // A conversion cannot proceed if the oscillator is off now or is about to be.
  function automatic logic stall_on_commit(input logic [CFG_W-1:0] old_cfg,
                                           input logic [CFG_W-1:0] new_cfg);
    return old_cfg[F_OPD] | new_cfg[F_OPD];
  endfunction
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              sdo_o,
  output logic              frame_active_o,
  output logic              frame_ok_o,
  output logic [WORD_W-1:0] frame_word_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic sclk_d, csn_d;
  logic [WORD_W-1:0] in_q, out_q;
  logic [CNT_W-1:0]  cnt_q;

  wire cs_fall = csn_d & ~csn_s;
  wire cs_rise = ~csn_d & csn_s;
  wire sck_rise = ~sclk_d & sclk_s & ~csn_s;
  wire sck_fall = sclk_d & ~sclk_s & ~csn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
      in_q   <= '0;
      out_q  <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
      if (cs_fall) begin
        out_q <= load_word_i;
        cnt_q <= '0;
      end else begin
        if (sck_rise) begin
          in_q <= {in_q[WORD_W-2:0], sdi_s};
          if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
        end
        if (sck_fall) out_q <= {out_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sdo_o          = out_q[WORD_W-1];
  assign frame_active_o = ~csn_s;
  assign frame_ok_o     = cs_rise && (cnt_q == CNT_FULL);
  assign frame_word_o   = in_q;
endmodule

// File: rtl/sadc_seq.sv
module sadc_seq
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_active_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] result_i,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [WORD_W-1:0] io_word_o,
  output logic              busy_n_o,
  output logic              conv_start_o,
  output logic              commit_ev_o,
  output logic              noop_ev_o,
  output logic              load_ev_o
);
  seq_st_t st_q;
  logic    stall_now;

  assign commit_ev_o = frame_ok_i & word_i[FLAG_BIT];
  assign noop_ev_o   = frame_ok_i & ~word_i[FLAG_BIT];
  assign load_ev_o   = done_i & (st_q == SQ_RUN) & ~frame_active_i;
  assign stall_now   = stall_on_commit(cfg_o, word_i[CFG_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o        <= '0;
      io_word_o    <= '0;
      st_q         <= SQ_IDLE;
      conv_start_o <= 1'b0;
    end else begin
      conv_start_o <= 1'b0;
      if (commit_ev_o) begin
        cfg_o        <= word_i[CFG_W-1:0];
        st_q         <= stall_now ? SQ_STALL : SQ_RUN;
        conv_start_o <= ~stall_now;
      end else if (noop_ev_o) begin
        st_q <= SQ_IDLE;
      end else if (load_ev_o) begin
        io_word_o <= result_i;
        st_q      <= SQ_IDLE;
      end
    end
  end

  assign busy_n_o = (st_q == SQ_IDLE);
endmodule

// File: rtl/sadc_ctrl_if.sv
module sadc_ctrl_if
  import sadc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              done_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              busy_n_o,
  output logic              conv_start_o,
  output logic              osc_en_o,
  output logic              apd_o,
  output logic              null_o,
  output logic              gcal_o,
  output logic              chan_o,
  output logic [F_DIV_W-1:0]  div_sel_o,
  output logic [F_TIME_W-1:0] time_sel_o
);
  logic [2:0] raw_in, syn_in;
  logic sclk_s, csn_s, sdi_s;
  logic frame_active, frame_ok;
  logic [WORD_W-1:0] frame_word, io_word;
  logic [CFG_W-1:0]  cfg;
  logic commit_ev, noop_ev, load_ev;

  assign raw_in = {sclk_i, csn_i, sdi_i};
  assign {sclk_s, csn_s, sdi_s} = syn_in;

  sadc_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in)
  );

  sadc_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .load_word_i(io_word), .sdo_o(sdo_o), .frame_active_o(frame_active),
    .frame_ok_o(frame_ok), .frame_word_o(frame_word)
  );

  sadc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_ok_i(frame_ok), .word_i(frame_word),
    .frame_active_i(frame_active), .done_i(done_i), .result_i(result_i),
    .cfg_o(cfg), .io_word_o(io_word), .busy_n_o(busy_n_o),
    .conv_start_o(conv_start_o), .commit_ev_o(commit_ev),
    .noop_ev_o(noop_ev), .load_ev_o(load_ev)
  );

  assign sdo_oe_o   = frame_active;
  assign osc_en_o   = ~cfg[F_OPD];
  assign apd_o      = cfg[F_APD];
  assign null_o     = cfg[F_NULL];
  assign gcal_o     = cfg[F_GCAL];
  assign chan_o     = cfg[F_CHAN];
  assign div_sel_o  = cfg[F_DIV_LO +: F_DIV_W];
  assign time_sel_o = cfg[F_TIME_LO +: F_TIME_W];
endmodule

// File: rtl/sadc_ctrl_if_chk.sv
module sadc_ctrl_if_chk
  import sadc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_ok,
  input logic              frame_active,
  input logic [WORD_W-1:0] frame_word,
  input logic [CFG_W-1:0]  cfg,
  input logic [WORD_W-1:0] io_word,
  input logic              done_i,
  input logic              busy_n_o,
  input logic              conv_start_o,
  input logic              osc_en_o,
  input logic              sdo_oe_o
);
  a_r2_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_word[FLAG_BIT]) |=> cfg == $past(frame_word[CFG_W-1:0]));

  a_r3_noop_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && !frame_word[FLAG_BIT]) |=> ($stable(cfg) && busy_n_o && !conv_start_o));

  a_r4_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !sdo_oe_o);

  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> (!busy_n_o && osc_en_o));

  a_r7_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && frame_active) |=> $stable(io_word));

  a_r8_osc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && frame_word[FLAG_BIT] && frame_word[1]) |=> !osc_en_o);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n_o && !osc_en_o && !frame_ok) |=> !busy_n_o);
endmodule

bind sadc_ctrl_if sadc_ctrl_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_active(frame_active),
  .frame_word(frame_word), .cfg(cfg), .io_word(io_word), .done_i(done_i),
  .busy_n_o(busy_n_o), .conv_start_o(conv_start_o), .osc_en_o(osc_en_o),
  .sdo_oe_o(sdo_oe_o)
);

// File: tb/sadc_ctrl_if_bench.sv
module sadc_ctrl_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0, done_i = 1'b0;
  logic [15:0] result_i = '0;
  logic sdo_o, sdo_oe_o, busy_n_o, conv_start_o, osc_en_o;
  logic apd_o, null_o, gcal_o, chan_o;
  logic [1:0] div_sel_o;
  logic [3:0] time_sel_o;

  always #10 clk = ~clk;

  sadc_ctrl_if u_sadc_ctrl_if (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .done_i(done_i), .result_i(result_i),
    .busy_n_o(busy_n_o), .conv_start_o(conv_start_o), .osc_en_o(osc_en_o),
    .apd_o(apd_o), .null_o(null_o), .gcal_o(gcal_o), .chan_o(chan_o),
    .div_sel_o(div_sel_o), .time_sel_o(time_sel_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit settled = 0;
  bit done_flag = 0;

  // reference model state
  logic [14:0] m_cfg = '0;
  logic [15:0] m_io = '0;
  int m_state = 0;      // 0 idle, 1 converting, 2 stalled
  int m_starts = 0;
  int seen_starts = 0;
  string cur_req = "R1";

  always @(posedge clk) if (conv_start_o) seen_starts++;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every settled clock: compare all outputs with the model
  always @(negedge clk) begin
    if (settled && !done_flag) begin
      chk(cur_req, "busy_n", busy_n_o, m_state == 0);
      chk("R8", "osc_en", osc_en_o, !m_cfg[1]);
      chk("R5", "apd", apd_o, m_cfg[0]);
      chk("R5", "null", null_o, m_cfg[2]);
      chk("R5", "gcal", gcal_o, m_cfg[3]);
      chk("R5", "chan", chan_o, m_cfg[4]);
      chk("R5", "div_sel", div_sel_o, m_cfg[8:7]);
      chk("R5", "time_sel", time_sel_o, m_cfg[12:9]);
      chk("R4", "sdo_oe idle", sdo_oe_o, 0);
      chk("R6", "start count", seen_starts, m_starts);
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int nclk, input bit inject_done,
                       input logic [15:0] inj_val, input string req);
    logic [15:0] got = '0;
    logic [15:0] exp_out = m_io;
    settled = 0;
    cur_req = req;
    csn_i = 1'b0;
    wclk(8);
    for (int i = 0; i < nclk; i++) begin
      sdi_i = (i < 16) ? w[15-i] : 1'b0;
      wclk(8);
      if (i < 16) got[15-i] = sdo_o;
      chk("R4", "sdo_oe in frame", sdo_oe_o, 1);
      if (inject_done && i == 4) begin
        result_i = inj_val; done_i = 1'b1; wclk(1); done_i = 1'b0;
      end
      sclk_i = 1'b1;
      wclk(8);
      sclk_i = 1'b0;
    end
    wclk(8);
    csn_i = 1'b1;
    wclk(6);
    if (nclk >= 16) chk(req == "R1" ? "R1" : "R4", "read-back word", got, exp_out);
    if (nclk == 16) begin
      if (w[15]) begin
        bit stall = m_cfg[1] | w[1];
        m_cfg = w[14:0];
        m_state = stall ? 2 : 1;
        if (!stall) m_starts++;
      end else m_state = 0;
    end
    settled = 1;
    wclk(4);
  endtask

  task automatic done_pulse(input logic [15:0] v, input string req);
    cur_req = req;
    result_i = v; done_i = 1'b1; wclk(1); done_i = 1'b0;
    if (m_state == 1) begin m_io = v; m_state = 0; end
    wclk(4);
  endtask

  // word builder: flag, apd, opd, null, gcal, chan, div, time
  function automatic logic [15:0] mk(input bit f, input bit apd, input bit opd,
      input bit nul, input bit gc, input bit ch, input logic [1:0] dv, input logic [3:0] tm);
    logic [15:0] w = '0;
    w[15] = f; w[0] = apd; w[1] = opd; w[2] = nul; w[3] = gc; w[4] = ch;
    w[8:7] = dv; w[12:9] = tm;
    return w;
  endfunction

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    settled = 1;
    wclk(4);
    // R1: reset values and first read-back of zeros
    chk("R1", "busy_n reset", busy_n_o, 1);
    chk("R1", "osc_en reset", osc_en_o, 1);
    frame(16'h0000, 16, 0, 0, "R1");
    // R2/R5/R6: commit a word, fields decode, conversion starts
    frame(mk(1, 0, 0, 1, 0, 1, 2'd2, 4'hA), 16, 0, 0, "R2");
    chk("R6", "busy after commit", busy_n_o, 0);
    done_pulse(16'h1234, "R7");
    chk("R7", "busy released", busy_n_o, 1);
    frame(16'h0000, 16, 0, 0, "R3");   // read back 1234
    // R7: done while idle ignored
    done_pulse(16'hFFFF, "R7");
    frame(mk(1, 1, 0, 0, 1, 0, 2'd1, 4'h5), 16, 0, 0, "R5");  // reads 1234
    // R7: done during a frame ignored
    frame(16'h0000 | 16'h0010, 16, 1, 16'hBEEF, "R3");  // noop, ends conversion
    frame(mk(1, 0, 0, 0, 0, 1, 2'd3, 4'hF), 16, 1, 16'hBEEF, "R7");
    chk("R7", "busy still low", busy_n_o, 0);
    done_pulse(16'hA5C3, "R7");
    // R10: malformed frames discarded
    frame(mk(1, 1, 1, 1, 1, 0, 2'd0, 4'h3), 15, 0, 0, "R10");
    frame(mk(1, 1, 1, 1, 1, 0, 2'd0, 4'h3), 17, 0, 0, "R10");
    frame(16'h0000, 16, 0, 0, "R10");   // reads A5C3
    // R3: no-op while converting returns to idle, cfg kept
    frame(mk(1, 0, 0, 1, 1, 0, 2'd2, 4'h7), 16, 0, 0, "R2");
    frame(mk(0, 1, 1, 0, 0, 1, 2'd1, 4'h1), 16, 0, 0, "R3");
    // R8/R9: oscillator power-down leads to a stall
    frame(mk(1, 0, 1, 0, 0, 0, 2'd0, 4'h2), 16, 0, 0, "R9");
    chk("R8", "osc off", osc_en_o, 0);
    done_pulse(16'h5555, "R9");
    chk("R9", "stall survives done", busy_n_o, 0);
    frame(mk(1, 0, 0, 0, 0, 1, 2'd1, 4'h2), 16, 0, 0, "R9");
    chk("R8", "osc back on", osc_en_o, 1);
    chk("R9", "still stalled", busy_n_o, 0);
    frame(16'h0000, 16, 0, 0, "R9");   // dummy word clears stall
    frame(mk(1, 0, 0, 0, 1, 0, 2'd2, 4'h9), 16, 0, 0, "R6");
    done_pulse(16'h0F0F, "R7");
    frame(16'h0000, 16, 0, 0, "R4");   // reads 0F0F
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule